// File: doc/BRIEF.md
# Lane ULPS Exit Sequencer

This block brings a set of serial link lanes (three data lanes plus one clock lane) into and out of the ultra-low-power state. It drives two control outputs per lane: an escape request that holds the lane in the low-power state, and an exit request that asks the PHY to leave it. A one-cycle command pulse chooses the lanes and the operation. Entry raises the escape request on the chosen lanes. Exit runs a fixed handshake. The block first raises exit, then waits until every chosen lane reports that it is no longer in the low-power state. It then times the wake-up interval and drops both control bits together.

Each lane reports its state on an active-low status input. When all chosen lanes have reported, the block sets a status bit and raises an interrupt. If the I/O power field reads zero, the handshake is shortened or abandoned and the block goes straight to the release step. Every release, and every entry, must be seen back on the lane outputs before the block returns to idle. While a sequence runs, all other commands are refused and an error flag is set.

Top module: `ulps_exit_seq`

## Requirements
- R1: After reset, all escape and exit outputs are 0, busy is 0, the status word is 0 and irq is 0.
- R2: The command code 2'b01 (enter) sets the escape output of every selected lane in the next cycle. Busy stays high for exactly one cycle, the readback check. Lane bits 0 to 2 are data lanes 1 to 3, and bit 3 is the clock lane.
- R3: The command code 2'b10 (exit) with a nonzero power field sets the exit output of the selected lanes in the next cycle and leaves the escape outputs unchanged.
- R4: During an exit, the wake-up timer starts only when every selected lane's status input is 1. Status inputs of lanes that are not selected have no effect.
- R5: When all selected lanes have acknowledged, status bit 31 is set and irq goes high. Writing a 1 to bit 31 clears it, and writing 0 to bit 31 leaves it set.
- R6: WAKE_CYCLES cycles after the acknowledge is seen, the escape and exit outputs of the selected lanes are cleared in the same cycle. Busy lasts WAKE_CYCLES+2+d cycles, where d is the acknowledge delay in cycles after the command (d of at least 1).
- R7: Busy stays high until the cleared bits are read back as 0. It falls one cycle after the release.
- R8: A command that arrives while busy is ignored, and status bit 0 (write-one-to-clear) is set.
- R9: An exit command given while the power field is 2'b00 never raises exit. It clears the escape outputs of the selected lanes, keeps busy high for 2 cycles and does not set bit 31.
- R10: If the power field becomes 2'b00 during the acknowledge wait or the wake-up wait, the wait is abandoned. Both bits are cleared, and busy ends 2 cycles after the power-off is sampled.
- R11: A command with no lane selected, or with code 2'b00 or 2'b11, is ignored. Busy stays 0 and the error bit is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | 01 enter, 10 exit |
| cmd_lanes | input | NUM_DATA_LANES+1 | Lane select; top bit is the clock lane |
| io_pwr | input | 2 | I/O power field; 00 means off |
| sts_wr | input | 1 | Status write strobe |
| sts_w1c | input | 32 | Write-one-to-clear mask for the status word |
| lane_ulps_n | input | NUM_DATA_LANES+1 | Per-lane status, 1 = not in low-power state |
| esc_req | output | NUM_DATA_LANES+1 | Per-lane escape request |
| ulps_exit | output | NUM_DATA_LANES+1 | Per-lane exit request |
| busy | output | 1 | A sequence is in progress |
| status | output | 32 | Bit 31 all-acknowledged, bit 0 command error |
| irq | output | 1 | Follows status bit 31 |

## Verification
Some properties are checked on every cycle. The lane outputs must not move during either wait. Set and clear must never hit the same lane together. The timer must count down by one. The acknowledge flag may rise only out of the acknowledge wait. A refused command must set the error bit, and the release check must see the selected bits as 0. Other behaviour only shows up over a whole sequence, so the bench's directed and random scenarios cover it: the busy length as a function of the acknowledge delay and the power-off timing, whether exit is ever raised on a powered-off start, and the lane state left behind after an ignored command.

// File: rtl/ulps_seq_pkg.sv
// Package: shared state encoding, command codes and status bit positions
// for the lane low-power sequencer. Assumes a two-bit command code.
package ulps_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER_CHK,
        ST_ACK_WAIT,
        ST_WAKE,
        ST_RELEASE,
        ST_REL_CHK
    } seq_state_e;

    localparam logic [1:0] OP_ENTER = 2'b01;
    localparam logic [1:0] OP_EXIT  = 2'b10;
    localparam logic [1:0] PWR_OFF  = 2'b00;

    localparam int STS_ACK_BIT = 31;
    localparam int STS_ERR_BIT = 0;
endpackage

// File: rtl/ulps_lane_bank.sv
// Per-lane control bits: escape request and exit request.
// A clear takes priority over a set. The sequencer never issues both for
// the same lane in one cycle, and an assertion guards this.
module ulps_lane_bank #(
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] set_esc,
    input  logic [NL-1:0] set_exit,
    input  logic [NL-1:0] clr,
    output logic [NL-1:0] esc_q,
    output logic [NL-1:0] exit_q
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        // one lane: hold, set or clear its two control bits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                esc_q[i]  <= 1'b0;
                exit_q[i] <= 1'b0;
            end else if (clr[i]) begin
                esc_q[i]  <= 1'b0;
                exit_q[i] <= 1'b0;
            end else begin
                if (set_esc[i])  esc_q[i]  <= 1'b1;
                if (set_exit[i]) exit_q[i] <= 1'b1;
            end
        end
    end

    // set and clear never target the same lane together (R6)
    always_comb begin
        if (rst_n) begin
            p_no_set_clr_r6: assert (((set_esc | set_exit) & clr) == '0)
                else $error("set and clear collide on a lane");
        end
    end
endmodule

// File: rtl/ulps_wake_timer.sv
// Wake-up interval timer. A start pulse loads WAKE_CYCLES-1. The done
// output is high in the final counted cycle. Abort stops the count.
// Assumes WAKE_CYCLES >= 1.
module ulps_wake_timer #(
    parameter int WAKE_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAKE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // load, count down and stop the interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (abort) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

    // a running count drops by one each cycle (R6)
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !start && !abort) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("wake timer skipped a count");
endmodule

// File: rtl/ulps_status.sv
// Status word. Bit 31 records that all lanes acknowledged, and bit 0
// records a refused command. Both are cleared by writing a 1, and a set
// in the same cycle wins. All other bits read 0.
module ulps_status
    import ulps_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_ack,
    input  logic        set_err,
    input  logic        wr,
    input  logic [31:0] w1c,
    output logic [31:0] status
);
    logic ack_q, err_q;
    logic unused_w1c;
    assign unused_w1c = ^w1c[30:1];

    // sticky flags with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (set_ack)                        ack_q <= 1'b1;
            else if (wr && w1c[STS_ACK_BIT])    ack_q <= 1'b0;
            if (set_err)                        err_q <= 1'b1;
            else if (wr && w1c[STS_ERR_BIT])    err_q <= 1'b0;
        end
    end

    always_comb begin
        status = '0;
        status[STS_ACK_BIT] = ack_q;
        status[STS_ERR_BIT] = err_q;
    end

    // writing one to bit 31 clears the flag (R5)
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && w1c[STS_ACK_BIT] && !set_ack) |=> !status[STS_ACK_BIT])
        else $error("acknowledge flag survived its clear");
endmodule

// File: rtl/ulps_exit_seq.sv
// Top level: lane low-power entry and exit sequencer.
// Runs the exit handshake (raise exit, wait for every selected lane to
// acknowledge, time the wake-up, release both bits, read back). It also
// runs entry with readback and the power-off shortcut. Assumes the
// command strobe lasts one cycle and the status inputs are already
// synchronous to clk.
module ulps_exit_seq
    import ulps_seq_pkg::*;
#(
    parameter int NUM_DATA_LANES = 3,
    parameter int WAKE_CYCLES    = 125000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [NUM_DATA_LANES:0] cmd_lanes,
    input  logic [1:0]              io_pwr,
    input  logic                    sts_wr,
    input  logic [31:0]             sts_w1c,
    input  logic [NUM_DATA_LANES:0] lane_ulps_n,
    output logic [NUM_DATA_LANES:0] esc_req,
    output logic [NUM_DATA_LANES:0] ulps_exit,
    output logic                    busy,
    output logic [31:0]             status,
    output logic                    irq
);
    localparam int NL = NUM_DATA_LANES + 1;

    seq_state_e    state_q, state_d;
    logic [NL-1:0] sel_q;
    logic [NL-1:0] set_esc, set_exit, clr;
    logic          tmr_start, tmr_abort, tmr_done;
    logic          ack_evt, accept, reject, pwr_off, all_ack;

    assign pwr_off = (io_pwr == PWR_OFF);
    assign accept  = cmd_valid && (state_q == ST_IDLE) && (|cmd_lanes)
                     && (cmd_op == OP_ENTER || cmd_op == OP_EXIT);
    assign reject  = cmd_valid && (state_q != ST_IDLE);
    assign all_ack = ((lane_ulps_n & sel_q) == sel_q);
    assign busy    = (state_q != ST_IDLE);

    // next state and lane write strobes for each sequence step
    always_comb begin
        state_d   = state_q;
        set_esc   = '0;
        set_exit  = '0;
        clr       = '0;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        ack_evt   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (cmd_op == OP_ENTER) begin
                    set_esc = cmd_lanes;
                    state_d = ST_ENTER_CHK;
                end else if (pwr_off) begin
                    state_d = ST_RELEASE;
                end else begin
                    set_exit = cmd_lanes;
                    state_d  = ST_ACK_WAIT;
                end
            end
            ST_ENTER_CHK: if ((esc_req & sel_q) == sel_q) state_d = ST_IDLE;
            ST_ACK_WAIT: begin
                if (pwr_off) begin
                    state_d = ST_RELEASE;
                end else if (all_ack) begin
                    ack_evt   = 1'b1;
                    tmr_start = 1'b1;
                    state_d   = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (pwr_off) begin
                    tmr_abort = 1'b1;
                    state_d   = ST_RELEASE;
                end else if (tmr_done) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                clr     = sel_q;
                state_d = ST_REL_CHK;
            end
            ST_REL_CHK: if (((esc_req | ulps_exit) & sel_q) == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and latched lane selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) sel_q <= cmd_lanes;
        end
    end

    ulps_lane_bank #(.NL(NL)) lanes_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_esc  (set_esc),
        .set_exit (set_exit),
        .clr      (clr),
        .esc_q    (esc_req),
        .exit_q   (ulps_exit)
    );

    ulps_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (tmr_abort),
        .done  (tmr_done)
    );

    ulps_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ack (ack_evt),
        .set_err (reject),
        .wr      (sts_wr),
        .w1c     (sts_w1c),
        .status  (status)
    );

    assign irq = status[STS_ACK_BIT];

    // lane outputs hold still through both waits (R4)
    p_wait_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_WAIT || state_q == ST_WAKE)
        |=> ($stable(esc_req) && $stable(ulps_exit)))
        else $error("lane bits moved during a wait");

    // the acknowledge flag rises only out of the acknowledge wait (R5)
    p_ack_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STS_ACK_BIT]) |-> $past(state_q == ST_ACK_WAIT))
        else $error("acknowledge flag set outside the wait");

    // a command refused while busy leaves the error bit set (R8)
    p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> status[STS_ERR_BIT])
        else $error("refused command not flagged");

    // the release check only ever sees the selected bits low (R7)
    p_release_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REL_CHK) |-> (((esc_req | ulps_exit) & sel_q) == '0))
        else $error("release not visible at readback");
endmodule

// File: tb/ulps_exit_seq_tb_top.sv
// Bench: directed corners plus seeded random sequences. Expected busy
// lengths and flags come from bench functions derived from the requirements.
module ulps_exit_seq_tb_top;
    localparam int ND = 3;
    localparam int NL = ND + 1;
    localparam int W  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [NL-1:0] cmd_lanes = '0;
    logic [1:0]    io_pwr = 2'b11;
    logic          sts_wr = 1'b0;
    logic [31:0]   sts_w1c = '0;
    logic [NL-1:0] lane_ulps_n = '0;
    logic [NL-1:0] esc_req, ulps_exit;
    logic          busy, irq;
    logic [31:0]   status;

    int n_chk = 0;
    int n_bad = 0;
    logic [NL-1:0] esc_model = '0;

    always #4 clk = ~clk;

    ulps_exit_seq #(.NUM_DATA_LANES(ND), .WAKE_CYCLES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lanes(cmd_lanes), .io_pwr(io_pwr), .sts_wr(sts_wr),
        .sts_w1c(sts_w1c), .lane_ulps_n(lane_ulps_n), .esc_req(esc_req),
        .ulps_exit(ulps_exit), .busy(busy), .status(status), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit valid_cmd(input logic [1:0] op, input logic [NL-1:0] ln);
        return (ln != '0) && (op == 2'b01 || op == 2'b10);
    endfunction

    // expected busy cycles (R2, R6, R9, R10, R11)
    function automatic int exp_busy(input logic [1:0] op, input logic [NL-1:0] ln,
                                    input bit off0, input int d, input int p);
        if (!valid_cmd(op, ln)) return 0;
        if (op == 2'b01) return 1;
        if (off0) return 2;
        if (p > 0 && (d == 0 || p <= d + W)) return p + 2;
        return d + W + 2;
    endfunction

    // expected acknowledge flag (R5)
    function automatic bit exp_ack(input logic [1:0] op, input logic [NL-1:0] ln,
                                   input bit off0, input int d, input int p);
        if (!valid_cmd(op, ln) || op != 2'b10 || off0) return 1'b0;
        return (d > 0) && (p == 0 || p > d);
    endfunction

    task automatic clear_status(input logic [31:0] mask);
        @(negedge clk);
        sts_wr = 1'b1;
        sts_w1c = mask;
        @(negedge clk);
        sts_wr = 1'b0;
        sts_w1c = '0;
    endtask

    // one command: d = ack delay (0 none), p = power-off cycle (0 none),
    // off0 = powered off before the command, inj = cycle of a refused command
    task automatic run_cmd(input logic [1:0] op, input logic [NL-1:0] ln, input bit off0,
                           input int d, input int p, input int inj, input string tag);
        int bcnt = 0;
        logic [NL-1:0] exit_seen = '0;
        logic [NL-1:0] esc_before = esc_req;
        bit is_exit = valid_cmd(op, ln) && op == 2'b10;
        @(negedge clk);
        if (op == 2'b10) lane_ulps_n = '0;
        if (off0) io_pwr = 2'b00;
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_lanes = ln;
        for (int k = 1; k < W + 60; k++) begin
            @(negedge clk);
            exit_seen |= ulps_exit;
            if (k == 1 && is_exit && !off0) begin
                check((ulps_exit & ln) == ln, {tag, " R3 exit raised"}, ulps_exit, ln);
                check(esc_req == esc_before, {tag, " R3 escape kept"}, esc_req, esc_before);
            end
            if (k == 1 && op == 2'b01 && valid_cmd(op, ln))
                check((esc_req & ln) == ln, {tag, " R2 escape set"}, esc_req, ln);
            if (!busy) break;
            bcnt++;
            cmd_valid = (k == inj);
            if (k == inj) begin
                cmd_op = 2'b01;
                cmd_lanes = '1;
            end
            if (k == d) lane_ulps_n |= ln;
            if (k == p) io_pwr = 2'b00;
        end
        cmd_valid = 1'b0;
        io_pwr = 2'b11;
        check(bcnt == exp_busy(op, ln, off0, d, p), {tag, " R6/R7/R10 busy length"},
              bcnt, exp_busy(op, ln, off0, d, p));
        check(status[31] == exp_ack(op, ln, off0, d, p) && irq == status[31],
              {tag, " R5 acknowledge flag"}, status[31], exp_ack(op, ln, off0, d, p));
        check(status[0] == (inj > 0), {tag, " R8/R11 error flag"}, status[0], inj > 0);
        if (off0) check(exit_seen == '0, {tag, " R9 exit never raised"}, exit_seen, 0);
        if (valid_cmd(op, ln)) begin
            if (op == 2'b01) esc_model |= ln;
            else             esc_model &= ~ln;
        end
        check(esc_req == esc_model, {tag, " R6/R8 escape state"}, esc_req, esc_model);
        check(ulps_exit == '0, {tag, " R6 exit released"}, ulps_exit, 0);
        clear_status('1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(esc_req == '0 && ulps_exit == '0 && !busy, "R1 reset lanes", {esc_req, ulps_exit}, 0);
        check(status == '0 && !irq, "R1 reset status", status, 0);
        rst_n = 1'b1;
        void'($urandom(32'd1234));

        run_cmd(2'b01, 4'b1111, 0, 0, 0, 0, "enter all");
        run_cmd(2'b10, 4'b0101, 0, 3, 0, 0, "exit d3");
        run_cmd(2'b01, 4'b0101, 0, 0, 0, 0, "re-enter");
        run_cmd(2'b10, 4'b1000, 1, 0, 0, 0, "exit powered off");
        run_cmd(2'b10, 4'b0011, 0, 0, 2, 0, "poff in ack wait");
        run_cmd(2'b01, 4'b1111, 0, 0, 0, 0, "enter again");
        run_cmd(2'b10, 4'b0110, 0, 2, 6, 0, "poff in wake");
        run_cmd(2'b10, 4'b1001, 0, 1, 0, 3, "refused while busy");
        run_cmd(2'b10, 4'b0000, 0, 1, 0, 0, "R11 empty select");
        run_cmd(2'b11, 4'b1111, 0, 1, 0, 0, "R11 bad code");

        // R5: a write with bit 31 clear keeps the flag
        run_cmd(2'b01, 4'b0001, 0, 0, 0, 0, "enter lane1");
        @(negedge clk);
        lane_ulps_n = '0;
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_lanes = 4'b0001;
        @(negedge clk);
        cmd_valid = 1'b0;
        lane_ulps_n = 4'b0001;
        repeat (W + 6) @(negedge clk);
        esc_model &= ~4'b0001;
        clear_status(32'h0000_0001);
        check(status[31] == 1'b1, "R5 flag kept on bit0 write", status[31], 1);
        clear_status(32'h8000_0000);
        check(status[31] == 1'b0 && !irq, "R5 flag cleared", status[31], 0);

        for (int it = 0; it < 40; it++) begin
            logic [1:0] op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            logic [NL-1:0] ln = NL'(1 + $urandom % 15);
            int sc = $urandom % 4;
            int d = 1 + $urandom % 5;
            int p = 0;
            bit off0 = 1'b0;
            int inj = ($urandom % 4 == 0) ? 1 : 0;
            if (sc == 1) off0 = 1'b1;
            if (sc == 2) begin d = 0; p = 1 + $urandom % 4; end
            if (sc == 3) p = d + 1 + $urandom % W;
            run_cmd(op, ln, off0, d, p, inj, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule